// File: doc/BRIEF.md
# Floating to Fixed Point Converter

This block takes a small floating-point number and writes it out as an exact two's complement fixed-point word. The input has a signed mantissa with 2 integer bits (the sign among them) and 4 fraction bits, and a signed integer exponent. The value it stands for is the mantissa times two to the power of the exponent. The output word is just wide enough to hold every value the inputs can reach, so no result ever needs rounding or saturation.

The conversion first sign-extends the mantissa to the output width. The binary point is placed at the lowest exponent. The word is then shifted left by the exponent plus a bias, which is a shift of 0 to 7 places with the default sizes. With these sizes the output is 13 bits: 5 integer bits (the sign among them) and 8 fraction bits. The result goes through a register with a synchronous active-high reset, so it appears one clock after the inputs.

Top module: `ftf_convert`

## Requirements
- R1: While `rst` is high at a rising clock edge, `fix_o` becomes all zeros after that edge, whatever the inputs are.
- R2: After each rising edge with `rst` low, `fix_o` as a signed 13-bit integer equals signed(`mant_i`) times 2^(signed(`exp_i`)+4), taking the inputs sampled at that edge. This means `fix_o` is a 13-bit word with 8 fraction bits.
- R3: With `exp_i` = 3'b100 (exponent -4), `fix_o` equals `mant_i` sign-extended to 13 bits, so its LSB has weight 2^-8.
- R4: With `exp_i` = 3'b011 (exponent +3), the 7 lowest bits of `fix_o` are zero and bits 12:7 equal `mant_i`.
- R5: Bit 12 of `fix_o` (the sign) equals bit 5 of `mant_i` for every input.
- R6: The extreme results are exact. Mantissa 6'b100000 with exponent +3 gives 13'h1000 (-16). Mantissa 6'b011111 with exponent +3 gives 13'h0F80 (15.5). Mantissa 6'b000001 with exponent -4 gives 13'h0001 (2^-8).
- R7: A zero mantissa gives a zero output for every exponent.
- R8: The lowest (exponent+4) bits of `fix_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mant_i | input | 6 | Mantissa, two's complement, 2 integer and 4 fraction bits |
| exp_i | input | 3 | Exponent, two's complement integer, -4 to +3 |
| fix_o | output | 13 | Result, two's complement, 5 integer and 8 fraction bits |

## Verification
The assertions assume that the mantissa and exponent are known (not X) at every rising edge outside reset. They also assume every bit pattern of the two inputs is legal, since the exponent field has no reserved codes. The stimulus changes the inputs only on falling edges, holds them steady across each rising edge, and goes through all 512 combinations of the two fields. It also raises reset while the inputs are nonzero.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
  localparam int DEF_MANT_W    = 6;
  localparam int DEF_MANT_FRAC = 4;
  localparam int DEF_EXP_W     = 3;

  function automatic int exp_low(input int ew);
    return -(1 << (ew - 1));
  endfunction

  function automatic int exp_high(input int ew);
    return (1 << (ew - 1)) - 1;
  endfunction
endpackage

// File: rtl/ftf_sign_ext.sv
module ftf_sign_ext #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 13
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end else begin : g_nopad
      assign val_o = val_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ftf_shift_amt.sv
module ftf_shift_amt #(
  parameter int EXP_W = 3
) (
  input  logic [EXP_W-1:0] exp_i,
  output logic [EXP_W-1:0] amt_o
);
  localparam logic [EXP_W-1:0] BIAS = EXP_W'(1 << (EXP_W - 1));

  // Adding the bias modulo 2^EXP_W maps the most negative exponent to 0.
  assign amt_o = exp_i + BIAS;
endmodule

// File: rtl/ftf_barrel.sv
module ftf_barrel #(
  parameter int W    = 13,
  parameter int SH_W = 3
) (
  input  logic [W-1:0]    val_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    val_o
);
  logic [W-1:0] stage [0:SH_W];

  assign stage[0] = val_i;

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      assign stage[i+1] = amt_i[i] ? (stage[i] << (1 << i)) : stage[i];
    end
  endgenerate

  assign val_o = stage[SH_W];
endmodule

// File: rtl/ftf_convert.sv
module ftf_convert
  import ftf_pkg::*;
#(
  parameter int MANT_W    = DEF_MANT_W,
  parameter int MANT_FRAC = DEF_MANT_FRAC,
  parameter int EXP_W     = DEF_EXP_W,
  localparam int SHIFT_MAX = exp_high(EXP_W) - exp_low(EXP_W),
  localparam int OUT_W     = MANT_W + SHIFT_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [OUT_W-1:0]  fix_o
);
  localparam int OUT_FRAC = MANT_FRAC - exp_low(EXP_W);

  logic [OUT_W-1:0] ext_w;
  logic [EXP_W-1:0] amt_w;
  logic [OUT_W-1:0] shifted_w;
  logic [OUT_W-1:0] fix_q;

  ftf_sign_ext #(.IN_W(MANT_W), .OUT_W(OUT_W)) u_ext (
    .val_i (mant_i),
    .val_o (ext_w)
  );

  ftf_shift_amt #(.EXP_W(EXP_W)) u_amt (
    .exp_i (exp_i),
    .amt_o (amt_w)
  );

  ftf_barrel #(.W(OUT_W), .SH_W(EXP_W)) u_shift (
    .val_i (ext_w),
    .amt_i (amt_w),
    .val_o (shifted_w)
  );

  always_ff @(posedge clk) begin
    if (rst) fix_q <= '0;
    else     fix_q <= shifted_w;
  end

  assign fix_o = fix_q;

  initial begin
    if (OUT_FRAC < 0) $display("ftf_convert: fraction width below zero");
  end
endmodule

// File: rtl/ftf_convert_chk.sv
module ftf_convert_chk #(
  parameter int MANT_W = 6,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [MANT_W-1:0] mant_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic [OUT_W-1:0]  fix_o
);
  localparam int BIAS = 1 << (EXP_W - 1);

  logic             seen;
  logic [OUT_W-1:0] want_q;
  logic [OUT_W-1:0] mask_q;
  logic             sign_q;
  logic             zero_q;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
    want_q <= OUT_W'(int'($signed(mant_i)) * (1 << (int'($signed(exp_i)) + BIAS)));
    mask_q <= OUT_W'((1 << (int'($signed(exp_i)) + BIAS)) - 1);
    sign_q <= mant_i[MANT_W-1];
    zero_q <= (mant_i == '0);
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (fix_o == '0));

  a_r2_value: assert property (@(posedge clk) disable iff (rst)
    seen |-> (fix_o == want_q));

  a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
    seen |-> (fix_o[OUT_W-1] == sign_q));

  a_r7_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
    (seen && zero_q) |-> (fix_o == '0));

  a_r8_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
    seen |-> ((fix_o & mask_q) == '0));
endmodule

bind ftf_convert ftf_convert_chk #(
  .MANT_W (MANT_W),
  .EXP_W  (EXP_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mant_i (mant_i),
  .exp_i  (exp_i),
  .fix_o  (fix_o)
);

// File: tb/ftf_convert_test.sv
module ftf_convert_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  mant = '0;
  logic [2:0]  ex = '0;
  logic [12:0] fix;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ftf_convert uut (
    .clk    (clk),
    .rst    (rst),
    .mant_i (mant),
    .exp_i  (ex),
    .fix_o  (fix)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (mant=%b exp=%b)", tag, act, exp_v, mant, ex);
    end
  endtask

  task automatic apply(input logic [5:0] m, input logic [2:0] e);
    @(negedge clk);
    mant = m;
    ex   = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", fix, 13'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < 512; k++) begin
      int m, e, want, sh;
      apply(k[5:0], k[8:6]);
      m    = int'($signed(mant));
      e    = int'($signed(ex));
      sh   = e + 4;
      want = m * (1 << sh);
      check("R2 value", fix, 13'(want));
      check("R5 sign", {12'h000, fix[12]}, {12'h000, mant[5]});
      check("R8 low bits", fix & 13'((1 << sh) - 1), 13'h0000);
      if (e == -4) check("R3 lowest exponent", fix, {{7{mant[5]}}, mant});
      if (e == 3)  check("R4 highest exponent", fix, {mant, 7'b0});
      if (m == 0)  check("R7 zero mantissa", fix, 13'h0000);
    end

    apply(6'b100000, 3'b011); check("R6 most negative", fix, 13'h1000);
    apply(6'b011111, 3'b011); check("R6 largest positive", fix, 13'h0F80);
    apply(6'b000001, 3'b100); check("R6 smallest positive", fix, 13'h0001);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset with live inputs", fix, 13'h0000);
    @(negedge clk);
    rst = 1'b0;
    apply(6'b010000, 3'b000); check("R2 after reset", fix, 13'h0100);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule